// File: doc/BRIEF.md
# Caller-ID Mode and Event Controller

This block sits behind a set of caller-ID signal detectors and turns their already-digital flags into two outputs for a host controller. The first is a detect indication (`det_o`). The second is an active-low interrupt (`irq_n_o`), modelled as an open-drain line that reads 0 when asserted and 1 when released. A 2-bit mode select chooses which detector drives each output. The four modes are alert-tone detect, FSK receive, zero-power and dial-tone detect.

The block adds three functions on top of the routing. It applies time hysteresis to the raw FSK level flag. It qualifies alert-tone bursts by their length, so that only a burst inside a duration window raises the interrupt when the tone ends. It latches the alert-tone and dial-tone interrupts until the host leaves the mode. All durations are counted in ticks of a slow enable that is divided down from the system clock. With the default parameters one tick is 1 ms at 125 MHz.

Top module: `cid_event_ctrl`

## Requirements
- R1: Mode select 2'b00 selects alert-tone detect, 2'b01 selects FSK receive, 2'b10 selects zero-power and 2'b11 selects dial-tone detect. `det_o` is registered and shows the selected source one clock after that source is sampled: the alert-tone flag, the filtered FSK level, the ring flag or the dial-tone flag.
- R2: In zero-power mode, `det_o` follows the ring flag and `irq_n_o` is its inverse, both one clock later. The alert-tone, dial-tone, FSK-level and retiming-request inputs have no effect on either output.
- R3: In alert-tone mode, when the tone flag falls after being high for N ticks with LOW_WIN_TICKS <= N <= HIGH_WIN_TICKS, `irq_n_o` goes to 0 two clocks after the falling edge is sampled.
- R4: In alert-tone mode, a burst shorter than LOW_WIN_TICKS or longer than HIGH_WIN_TICKS leaves `irq_n_o` at 1.
- R5: In alert-tone mode and in dial-tone mode, an asserted interrupt stays at 0 while the mode select is unchanged, whatever the detector flags do afterwards.
- R6: In FSK receive mode, the filtered level rises only after the raw level flag has been high for LVL_ON_TICKS consecutive ticks. A single low clock restarts the count.
- R7: In FSK receive mode, the filtered level falls only after the raw level flag has been low for LVL_OFF_TICKS consecutive ticks. A shorter dropout leaves it high.
- R8: In FSK receive mode, `irq_n_o` is the inverse of (retiming request OR ring flag), one clock later, and is not latched.
- R9: In dial-tone mode, a rising edge of the dial-tone flag asserts the interrupt two clocks later. A tone that is already present when the mode is entered counts as a rising edge.
- R10: A change of mode select clears every latched interrupt and every duration counter. When the new mode is alert-tone or dial-tone, `irq_n_o` reads 1 one clock after the change.
- R11: While reset is held, `det_o` is 0 and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Operating mode select |
| ring_det | input | 1 | Ring or line-reversal present |
| alert_tone | input | 1 | Alert dual tone present |
| dial_tone | input | 1 | Dial dual tone present |
| fsk_level | input | 1 | Raw FSK level above threshold |
| retime_req | input | 1 | Character-ready request from data retiming |
| det_o | output | 1 | Detect indication for the selected mode |
| irq_n_o | output | 1 | Active-low interrupt, open-drain style |

## Verification
Alert bursts of exactly LOW_WIN_TICKS and HIGH_WIN_TICKS ticks, and bursts one tick outside each of those lengths, are applied. These show that the window edges are inclusive and that the duration counter saturates instead of wrapping. The FSK level flag is held for one tick less and one tick more than each hysteresis time, and is also given a one-clock dropout. This separates a continuous-duration count from a plain accumulated count. Random ring, tone, level and retiming patterns in zero-power and FSK modes confirm that only the intended sources reach the outputs. Mode changes with a tone already present show that latches are cleared and that the dial-tone path re-arms.

// File: rtl/cid_evt_pkg.sv
// Shared types for the caller-ID mode and event controller.
package cid_evt_pkg;
    // Mode select encoding; fixed because the host drives it directly.
    typedef enum logic [1:0] {
        MODE_ALERT = 2'b00,
        MODE_FSK   = 2'b01,
        MODE_ZERO  = 2'b10,
        MODE_DIAL  = 2'b11
    } cid_mode_e;
endpackage

// File: rtl/cid_tick_gen.sv
// Slow timing enable: one-clock pulse every CLK_PER_TICK clocks.
// Assumes CLK_PER_TICK >= 2. Free-running after reset.
module cid_tick_gen #(
    parameter int CLK_PER_TICK = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(CLK_PER_TICK + 1);
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] div_q;

    // Divider counter wraps at LAST and emits the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_q == LAST) begin
            div_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // Ticks are isolated single-cycle pulses.
    a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/cid_level_hyst.sv
// Time hysteresis on the raw FSK level flag.
// The output turns on after ON_TICKS consecutive ticks of the raw flag high,
// and turns off after OFF_TICKS consecutive ticks low. Any clock where the
// raw flag equals the current output restarts the count.
// Held idle (output 0, count 0) while disabled or being cleared.
module cid_level_hyst #(
    parameter int ON_TICKS  = 25,
    parameter int OFF_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic tick_i,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_nxt;
    logic [CW-1:0] limit;

    // Threshold depends on which way the output would switch.
    always_comb begin
        run_nxt = run_q + 1'b1;
        limit   = lvl_o ? CW'(OFF_TICKS) : CW'(ON_TICKS);
    end

    // Count ticks of disagreement; flip once the threshold is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) begin
            lvl_o <= 1'b0;
            run_q <= '0;
        end else if (raw_i == lvl_o) begin
            run_q <= '0;
        end else if (tick_i) begin
            if (run_nxt >= limit) begin
                lvl_o <= ~lvl_o;
                run_q <= '0;
            end else begin
                run_q <= run_nxt;
            end
        end
    end

    // R6: output only rises while the raw flag was high.
    a_r6_rise_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_o) |-> $past(raw_i));
    // R7: output only falls by filtering when the raw flag was low.
    a_r7_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lvl_o) && $past(en_i) && !$past(clr_i)) |-> !$past(raw_i));
endmodule

// File: rtl/cid_alert_qual.sv
// Alert-tone burst duration qualifier.
// Counts ticks while the tone flag is high (saturating above HIGH_WIN) and
// emits a one-clock hit when the flag falls with the count inside
// [LOW_WIN, HIGH_WIN]. Idle while disabled or cleared.
module cid_alert_qual #(
    parameter int LOW_WIN  = 45,
    parameter int HIGH_WIN = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic tick_i,
    input  logic tone_i,
    output logic hit_o
);
    localparam int DW = $clog2(HIGH_WIN + 2);
    localparam logic [DW-1:0] LO = DW'(LOW_WIN);
    localparam logic [DW-1:0] HI = DW'(HIGH_WIN);

    logic [DW-1:0] dur_q;
    logic          tone_q;

    // Duration counter and previous tone state.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) begin
            dur_q  <= '0;
            tone_q <= 1'b0;
        end else begin
            tone_q <= tone_i;
            if (!tone_i)
                dur_q <= '0;
            else if (tick_i && dur_q <= HI)
                dur_q <= dur_q + 1'b1;
        end
    end

    // Falling edge with an in-window duration qualifies the burst.
    always_comb begin
        hit_o = en_i && !clr_i && tone_q && !tone_i && (dur_q >= LO) && (dur_q <= HI);
    end

    // R3: a qualification is a single pulse per burst.
    a_r3_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
    // R4: duration count never runs past its saturation value.
    a_r4_dur_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        dur_q <= HI + 1'b1);
endmodule

// File: rtl/cid_event_ctrl.sv
// Caller-ID mode and event controller (top).
// Decodes the mode select, routes detector flags to det_o and the active-low
// interrupt, filters the FSK level, qualifies alert bursts and latches
// alert/dial interrupts until the mode select changes.
// Assumes all flag inputs are synchronous to clk.
module cid_event_ctrl
    import cid_evt_pkg::*;
#(
    parameter int CLK_PER_TICK   = 125000,
    parameter int LVL_ON_TICKS   = 25,
    parameter int LVL_OFF_TICKS  = 8,
    parameter int LOW_WIN_TICKS  = 45,
    parameter int HIGH_WIN_TICKS = 90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       ring_det,
    input  logic       alert_tone,
    input  logic       dial_tone,
    input  logic       fsk_level,
    input  logic       retime_req,
    output logic       det_o,
    output logic       irq_n_o
);
    cid_mode_e mode_cur;
    cid_mode_e mode_q;
    logic      mode_chg;
    logic      tick;
    logic      lvl_filt;
    logic      alert_hit;
    logic      dial_q;
    logic      latch_q;
    logic      det_d;
    logic      irq_d;

    // Decode the current mode and detect a change against last cycle.
    always_comb begin
        mode_cur = cid_mode_e'(mode_sel);
        mode_chg = (mode_cur != mode_q);
    end

    // Remember the mode seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_ZERO;
        else        mode_q <= mode_cur;
    end

    cid_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick));

    cid_level_hyst #(.ON_TICKS(LVL_ON_TICKS), .OFF_TICKS(LVL_OFF_TICKS)) i_hyst (
        .clk(clk), .rst_n(rst_n), .en_i(mode_cur == MODE_FSK), .clr_i(mode_chg),
        .tick_i(tick), .raw_i(fsk_level), .lvl_o(lvl_filt));

    cid_alert_qual #(.LOW_WIN(LOW_WIN_TICKS), .HIGH_WIN(HIGH_WIN_TICKS)) i_qual (
        .clk(clk), .rst_n(rst_n), .en_i(mode_cur == MODE_ALERT), .clr_i(mode_chg),
        .tick_i(tick), .tone_i(alert_tone), .hit_o(alert_hit));

    // Dial-tone edge memory; cleared outside dial mode so entry re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_cur != MODE_DIAL || mode_chg) dial_q <= 1'b0;
        else                                             dial_q <= dial_tone;
    end

    // Interrupt latch for alert and dial modes, cleared on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg)
            latch_q <= 1'b0;
        else if (mode_cur == MODE_ALERT && alert_hit)
            latch_q <= 1'b1;
        else if (mode_cur == MODE_DIAL && dial_tone && !dial_q)
            latch_q <= 1'b1;
    end

    // Route sources for the selected mode.
    always_comb begin
        unique case (mode_cur)
            MODE_ALERT: begin det_d = alert_tone; irq_d = latch_q && !mode_chg;  end
            MODE_FSK:   begin det_d = lvl_filt;   irq_d = retime_req || ring_det; end
            MODE_ZERO:  begin det_d = ring_det;   irq_d = ring_det;               end
            default:    begin det_d = dial_tone;  irq_d = latch_q && !mode_chg;  end
        endcase
    end

    // Output registers; interrupt is released high when not asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_o   <= 1'b0;
            irq_n_o <= 1'b1;
        end else begin
            det_o   <= det_d;
            irq_n_o <= ~irq_d;
        end
    end

    // R2: in zero-power, det follows ring one clock later.
    a_r2_zero_det: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_ZERO) |=> (det_o == $past(ring_det)));
    // R5: a latched interrupt holds while the mode is unchanged.
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !mode_chg) |=> latch_q);
    // R10: entering a latched mode releases the interrupt.
    a_r10_clear_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && (mode_cur == MODE_ALERT || mode_cur == MODE_DIAL)) |=> irq_n_o);
    // R9: a dial-tone rising edge in steady dial mode sets the latch.
    a_r9_dial_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DIAL && mode_cur == MODE_DIAL && $rose(dial_tone)) |=> latch_q);
endmodule

// File: tb/test_cid_event_ctrl.sv
// Self-checking bench for cid_event_ctrl with a shortened tick.
module test_cid_event_ctrl;
    localparam int P   = 8;
    localparam int ON  = 25;
    localparam int OFF = 8;
    localparam int LO  = 45;
    localparam int HI  = 90;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic ring_det = 0, alert_tone = 0, dial_tone = 0, fsk_level = 0, retime_req = 0;
    logic det_o, irq_n_o;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cid_event_ctrl #(.CLK_PER_TICK(P), .LVL_ON_TICKS(ON), .LVL_OFF_TICKS(OFF),
                     .LOW_WIN_TICKS(LO), .HIGH_WIN_TICKS(HI)) i_cid_event_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ring_det(ring_det),
        .alert_tone(alert_tone), .dial_tone(dial_tone), .fsk_level(fsk_level),
        .retime_req(retime_req), .det_o(det_o), .irq_n_o(irq_n_o));

    function automatic logic exp_irq_fsk(logic ring, logic rt);
        return ~(ring | rt);
    endfunction

    function automatic logic exp_alert_irq_n(int ticks);
        return !(ticks >= LO && ticks <= HI);
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic burst(int ticks);
        alert_tone = 1;
        step(ticks * P);
        alert_tone = 0;
        step(3);
    endtask

    task automatic set_mode(logic [1:0] m);
        mode_sel = m;
        step(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd612));
        step(3);
        chk(det_o, 1'b0, "R11 det in reset");
        chk(irq_n_o, 1'b1, "R11 irq_n in reset");
        rst_n = 1;
        step(2);

        // R2: zero-power, random stimulus on every input
        for (int i = 0; i < 300; i++) begin
            logic r;
            r = 1'($urandom);
            ring_det = r;
            alert_tone = 1'($urandom); dial_tone = 1'($urandom);
            fsk_level = 1'($urandom); retime_req = 1'($urandom);
            step(1);
            chk(det_o, r, "R2 zero det");
            chk(irq_n_o, ~r, "R2 zero irq");
        end
        ring_det = 0; alert_tone = 0; dial_tone = 0; fsk_level = 0; retime_req = 0;

        // R8: FSK receive, random ring/retime, level low
        set_mode(2'b01);
        for (int i = 0; i < 300; i++) begin
            logic r, t;
            r = 1'($urandom); t = 1'($urandom);
            ring_det = r; retime_req = t;
            step(1);
            chk(irq_n_o, exp_irq_fsk(r, t), "R8 fsk irq");
            chk(det_o, 1'b0, "R1 fsk det low level");
        end
        ring_det = 0; retime_req = 0;
        step(2);

        // R6: rise after ON ticks
        fsk_level = 1;
        step((ON - 1) * P);
        chk(det_o, 1'b0, "R6 not yet on");
        step(2 * P);
        chk(det_o, 1'b1, "R6 on after window");
        // R7: short dropout keeps level high
        fsk_level = 0;
        step((OFF - 1) * P);
        chk(det_o, 1'b1, "R7 short dropout");
        fsk_level = 1;
        step(OFF * P);
        chk(det_o, 1'b1, "R7 restarted count");
        fsk_level = 0;
        step(OFF * P + 2);
        chk(det_o, 1'b0, "R7 off after window");
        // R6: one-clock dropout restarts count
        fsk_level = 1; step(20 * P);
        fsk_level = 0; step(1);
        fsk_level = 1; step(20 * P);
        chk(det_o, 1'b0, "R6 dropout restarts");
        step(6 * P);
        chk(det_o, 1'b1, "R6 on after restart");
        fsk_level = 0;

        // R3/R4: alert bursts, boundaries included
        set_mode(2'b00);
        chk(det_o, 1'b0, "R10 det after entry");
        chk(irq_n_o, 1'b1, "R10 irq released on entry");
        begin
            int lens[6] = '{20, LO - 1, HI + 1, 120, LO, HI};
            foreach (lens[k]) begin
                alert_tone = 1;
                step(P);
                chk(det_o, 1'b1, "R1 alert det follows tone");
                step((lens[k] - 1) * P);
                alert_tone = 0;
                step(3);
                chk(irq_n_o, exp_alert_irq_n(lens[k]),
                    (lens[k] >= LO && lens[k] <= HI) ? "R3 in-window burst" : "R4 out-of-window burst");
                // R5: hold across further activity
                if (lens[k] >= LO && lens[k] <= HI) begin
                    burst(10);
                    step(200);
                    chk(irq_n_o, 1'b0, "R5 alert latch held");
                end
                // R10: leave and re-enter clears
                set_mode(2'b01);
                chk(irq_n_o, 1'b1, "R10 cleared on mode change");
                set_mode(2'b00);
            end
        end

        // R10 within one clock
        burst(60);
        chk(irq_n_o, 1'b0, "R3 burst 60");
        mode_sel = 2'b11;
        step(1);
        chk(irq_n_o, 1'b1, "R10 one-clock release");
        step(3);

        // R9: dial-tone edge
        dial_tone = 1;
        step(1);
        chk(det_o, 1'b1, "R1 dial det follows tone");
        step(1);
        chk(irq_n_o, 1'b0, "R9 dial edge irq");
        dial_tone = 0; ring_det = 1;
        step(50);
        chk(det_o, 1'b0, "R1 dial det low");
        chk(irq_n_o, 1'b0, "R5 dial latch held");
        ring_det = 0;
        // R9: tone present at entry re-arms
        dial_tone = 1;
        set_mode(2'b10);
        chk(irq_n_o, 1'b1, "R10 zero after dial");
        mode_sel = 2'b11;
        step(4);
        chk(irq_n_o, 1'b0, "R9 tone present at entry");
        dial_tone = 0;
        step(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule